// File: doc/BRIEF.md
# Card Data FIFO with Threshold and DMA Request Control

This block is the data buffer between the register side of a memory-card host controller and its card-side shifter. It holds up to 32 sixteen-bit words in a circular store. Either side may push or pop one word per cycle, and the transfer direction decides which side fills the store and which side drains it.

Two programmable thresholds watch the occupancy. An almost-full level applies when data comes in from the card. An almost-empty level applies when data goes out to the card. Each direction has its own DMA enable. When the threshold test for the active direction holds, the block raises the DMA request line for that direction if its DMA enable is set. Otherwise it sets a level bit in the shared status word, for interrupt-driven service. It never does both at once.

The block merges its two level bits into a status word supplied from outside. The interrupt output is high when any of the low fifteen status bits is set together with its enable bit.

Top module: `dataFifoLevel`

## Requirements
- R1: After reset the configuration reads 0x1F00: almost-full level 31, almost-empty level 0, both DMA enables off. Both DMA requests are low and status bits 10 and 11 are clear.
- R2: Words leave the FIFO in the order they entered. This holds through wrap-around of the 32-entry store, whether they are popped from the register side or the card side. The head word is presented combinationally on both read outputs.
- R3: A push while 32 words are held is discarded. The stored contents and the occupancy are unchanged.
- R4: A pop while the FIFO is empty returns the word at the start index and moves neither the start index nor the occupancy.
- R5: In the receive direction (dirRx=1), when occupancy is greater than the almost-full level (configuration bits 12:8), one of two things happens. If receive DMA is enabled (configuration bit 15), rxDmaReq is high and status bit 10 is clear. If it is not enabled, status bit 10 is set and rxDmaReq is low. When the test fails, both are low.
- R6: In the transmit direction (dirRx=0), when occupancy is less than the almost-empty level (configuration bits 4:0), one of two things happens. If transmit DMA is enabled (configuration bit 7), txDmaReq is high and status bit 11 is clear. If it is not enabled, status bit 11 is set and txDmaReq is low. When the test fails, both are low.
- R7: While xferActive is low and the FIFO is empty, both DMA requests are low and status bits 10 and 11 are clear, whatever the thresholds.
- R8: A configuration write that sets a DMA enable clears the matching level status bit in the cycle after the write.
- R9: irq is high exactly when some statusOut bit in positions 14:0 is set together with the same bit of intMask. Bit 15 never raises irq.
- R10: statusOut carries otherStatus unchanged except bits 10 and 11, which come from this block.
- R11: Level bits and DMA requests follow the occupancy with no lag. They are valid in the same cycle the occupancy changes after a push or pop edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRx | input | 1 | 1: card to host (receive); 0: host to card (transmit) |
| xferActive | input | 1 | A data transfer is in progress |
| regWrEn | input | 1 | Register-side push strobe |
| regWrData | input | 16 | Register-side push word |
| regRdEn | input | 1 | Register-side pop strobe |
| regRdData | output | 16 | Head word for the register side |
| cardPushEn | input | 1 | Card-side push strobe |
| cardPushData | input | 16 | Card-side push word |
| cardPopEn | input | 1 | Card-side pop strobe |
| cardPopData | output | 16 | Head word for the card side |
| cfgWrEn | input | 1 | Buffer configuration write strobe |
| cfgWrData | input | 16 | Buffer configuration write value |
| cfgRdData | output | 16 | Buffer configuration readback |
| otherStatus | input | 16 | Status bits owned by other logic |
| intMask | input | 15 | Interrupt enable per status bit |
| statusOut | output | 16 | Merged status word |
| irq | output | 1 | Interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
A wrong occupancy count shows up on the level bits and DMA request lines as soon as a threshold lies between the true and the wrong count. Because those outputs are combinational, the error appears in the same cycle the count goes wrong. A start index that drifts shows up on the next pop, as a head word out of order. An occupancy that underflows on an empty pop shows up at once, as a transmit level bit that drops although nothing was written. A discarded push that leaks into the store shows up when the 32 held words are drained and an extra word appears.

// File: rtl/dataFifoPkg.sv
package dataFifoPkg;
  localparam int DATA_W = 16;
  localparam int RX_LVL_BIT = 10;
  localparam int TX_LVL_BIT = 11;
  localparam int CFG_RX_DMA = 15;
  localparam int CFG_AF_LSB = 8;
  localparam int CFG_TX_DMA = 7;
  localparam int CFG_AE_LSB = 0;

  typedef struct packed {
    logic push;
    logic pop;
    logic [DATA_W-1:0] wdata;
  } fifoStrobe_t;
endpackage

// File: rtl/fifoStore.sv
module fifoStore
  import dataFifoPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  output logic [CNT_W-1:0]  fillCount,
  output logic [DATA_W-1:0] headWord
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] startIdx;
  logic [IDX_W-1:0] tailIdx;

  assign tailIdx  = startIdx + fillCount[IDX_W-1:0];
  assign headWord = mem[startIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.push) begin
      mem[tailIdx] <= strobe.wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startIdx  <= '0;
      fillCount <= '0;
    end else begin
      startIdx  <= startIdx + IDX_W'(strobe.pop);
      fillCount <= fillCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end
endmodule

// File: rtl/levelCtrl.sv
module levelCtrl
  import dataFifoPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam logic [15:0] LVL_ONES = 16'((1 << IDX_W) - 1),
  localparam logic [15:0] CFG_MASK = (16'h1 << CFG_RX_DMA) | (16'h1 << CFG_TX_DMA)
                                   | (LVL_ONES << CFG_AF_LSB) | (LVL_ONES << CFG_AE_LSB),
  localparam logic [15:0] CFG_RST  = 16'(DEPTH - 1) << CFG_AF_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRx,
  input  logic              xferActive,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  logic              cardPushEn,
  input  logic [DATA_W-1:0] cardPushData,
  input  logic              cardPopEn,
  input  logic              cfgWrEn,
  input  logic [15:0]       cfgWrData,
  input  logic [CNT_W-1:0]  fillCount,
  output fifoStrobe_t       strobe,
  output logic [15:0]       cfgRdData,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              rxLevel,
  output logic              txLevel
);
  logic [15:0] cfgReg;
  logic [IDX_W-1:0] afLevel, aeLevel;
  logic isFull, isEmpty, live, rxHit, txHit;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= CFG_RST;
    else if (cfgWrEn) cfgReg <= cfgWrData & CFG_MASK;
  end

  assign cfgRdData = cfgReg;
  assign afLevel   = cfgReg[CFG_AF_LSB +: IDX_W];
  assign aeLevel   = cfgReg[CFG_AE_LSB +: IDX_W];

  assign isFull  = (fillCount == CNT_W'(DEPTH));
  assign isEmpty = (fillCount == '0);

  always_comb begin
    strobe.push  = (regWrEn | cardPushEn) & ~isFull;
    strobe.pop   = (regRdEn | cardPopEn) & ~isEmpty;
    strobe.wdata = regWrEn ? regWrData : cardPushData;
  end

  assign live  = xferActive | ~isEmpty;
  assign rxHit = live & dirRx & (fillCount > {1'b0, afLevel});
  assign txHit = live & ~dirRx & (fillCount < {1'b0, aeLevel});

  assign rxDmaReq = rxHit & cfgReg[CFG_RX_DMA];
  assign rxLevel  = rxHit & ~cfgReg[CFG_RX_DMA];
  assign txDmaReq = txHit & cfgReg[CFG_TX_DMA];
  assign txLevel  = txHit & ~cfgReg[CFG_TX_DMA];
endmodule

// File: rtl/dataFifoLevel.sv
module dataFifoLevel
  import dataFifoPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRx,
  input  logic              xferActive,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  input  logic              regRdEn,
  output logic [15:0]       regRdData,
  input  logic              cardPushEn,
  input  logic [15:0]       cardPushData,
  input  logic              cardPopEn,
  output logic [15:0]       cardPopData,
  input  logic              cfgWrEn,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic [15:0]       otherStatus,
  input  logic [14:0]       intMask,
  output logic [15:0]       statusOut,
  output logic              irq,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  localparam logic [15:0] LVL_BITS = (16'h1 << RX_LVL_BIT) | (16'h1 << TX_LVL_BIT);

  fifoStrobe_t strobe;
  logic [CNT_W-1:0] fillCount;
  logic [15:0] headWord;
  logic rxLevel, txLevel;

  levelCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .xferActive(xferActive),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .cardPushEn(cardPushEn), .cardPushData(cardPushData), .cardPopEn(cardPopEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .fillCount(fillCount),
    .strobe(strobe), .cfgRdData(cfgRdData), .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq), .rxLevel(rxLevel), .txLevel(txLevel)
  );

  fifoStore #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillCount(fillCount), .headWord(headWord)
  );

  assign regRdData   = headWord;
  assign cardPopData = headWord;

  always_comb begin
    statusOut = otherStatus & ~LVL_BITS;
    statusOut[RX_LVL_BIT] = rxLevel;
    statusOut[TX_LVL_BIT] = txLevel;
  end

  assign irq = |(statusOut[14:0] & intMask);
endmodule

// File: rtl/dataFifoLevelChk.sv
module dataFifoLevelChk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fillCount,
  input logic             pushReq,
  input logic             popReq,
  input logic             xferActive,
  input logic             rxDmaReq,
  input logic             txDmaReq,
  input logic             rxLvl,
  input logic             txLvl,
  input logic             rxEnWrite
);
  // R3
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(DEPTH)) && pushReq && !popReq |=> fillCount == CNT_W'(DEPTH));
  // R4
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) && popReq && !pushReq |=> fillCount == '0);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive && (fillCount == '0) |-> !rxDmaReq && !txDmaReq && !rxLvl && !txLvl);
  // R5
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDmaReq && rxLvl));
  // R6
  tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txDmaReq && txLvl));
  // R8
  dma_en_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxEnWrite |=> !rxLvl);
endmodule

bind dataFifoLevel dataFifoLevelChk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fillCount(fillCount),
  .pushReq(regWrEn | cardPushEn), .popReq(regRdEn | cardPopEn),
  .xferActive(xferActive), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
  .rxLvl(statusOut[10]), .txLvl(statusOut[11]),
  .rxEnWrite(cfgWrEn & cfgWrData[15])
);

// File: tb/dataFifoLevel_bench.sv
`timescale 1ns/1ps
module dataFifoLevel_bench;
  logic clk = 0, rstN = 0;
  logic dirRx = 0, xferActive = 0;
  logic regWrEn = 0, regRdEn = 0, cardPushEn = 0, cardPopEn = 0, cfgWrEn = 0;
  logic [15:0] regWrData = 0, cardPushData = 0, cfgWrData = 0, otherStatus = 0;
  logic [14:0] intMask = 0;
  logic [15:0] regRdData, cardPopData, cfgRdData, statusOut;
  logic irq, rxDmaReq, txDmaReq;

  int total = 0, bad = 0, cycles = 0;
  logic [15:0] mdl [32];
  int mStart = 0, mCount = 0;

  always #2.5 clk = ~clk;

  dataFifoLevel u_dataFifoLevel (.*);

  typedef struct packed {
    logic dir; logic [15:0] cfg; logic [5:0] fill; logic [3:0] exp;
  } vec_t;
  // exp = {rxDmaReq, txDmaReq, status[10], status[11]}
  localparam vec_t VEC [11] = '{
    '{1'b1, 16'h0300, 6'd4,  4'b0010},
    '{1'b1, 16'h0300, 6'd3,  4'b0000},
    '{1'b1, 16'h8300, 6'd4,  4'b1000},
    '{1'b1, 16'h9F00, 6'd32, 4'b1000},
    '{1'b1, 16'h1F00, 6'd31, 4'b0000},
    '{1'b0, 16'h0005, 6'd4,  4'b0001},
    '{1'b0, 16'h0085, 6'd4,  4'b0100},
    '{1'b0, 16'h0085, 6'd5,  4'b0000},
    '{1'b0, 16'h0001, 6'd0,  4'b0001},
    '{1'b1, 16'h1F05, 6'd2,  4'b0000},
    '{1'b0, 16'h0100, 6'd3,  4'b0000}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushWord(input logic [15:0] w, input logic fromCard);
    @(negedge clk);
    if (fromCard) begin cardPushEn = 1; cardPushData = w; end
    else begin regWrEn = 1; regWrData = w; end
    @(negedge clk);
    cardPushEn = 0; regWrEn = 0;
    if (mCount < 32) begin mdl[(mStart + mCount) % 32] = w; mCount++; end
  endtask

  task automatic popWord(input logic fromCard, input string tag);
    logic [15:0] got;
    @(negedge clk);
    got = fromCard ? cardPopData : regRdData;
    chk(got == mdl[mStart], tag, got, mdl[mStart]);
    if (fromCard) cardPopEn = 1; else regRdEn = 1;
    @(negedge clk);
    cardPopEn = 0; regRdEn = 0;
    if (mCount > 0) begin mStart = (mStart + 1) % 32; mCount--; end
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  function automatic logic [3:0] flags();
    return {rxDmaReq, txDmaReq, statusOut[10], statusOut[11]};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(cfgRdData == 16'h1F00, "R1 cfg", cfgRdData, 16'h1F00);
    chk(flags() == 4'b0000, "R1 flags", flags(), 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // Table walk: R5 R6 (thresholds, DMA vs status, active direction only), R2 drain order
    for (int k = 0; k < 11; k++) begin
      writeCfg(VEC[k].cfg);
      dirRx = VEC[k].dir; xferActive = 1;
      for (int j = 0; j < int'(VEC[k].fill); j++)
        pushWord(16'h1000 + 16'(k * 64 + j), VEC[k].dir);
      @(negedge clk);
      chk(flags() == VEC[k].exp, VEC[k].dir ? "R5 rx table" : "R6 tx table",
          flags(), VEC[k].exp);
      for (int j = 0; j < int'(VEC[k].fill); j++) popWord(j[0], "R2 order");
    end

    // R7 idle and empty: nothing raised even with a threshold that would hit
    writeCfg(16'h0081); dirRx = 0; xferActive = 0;
    @(negedge clk);
    chk(flags() == 4'b0000, "R7 idle empty", flags(), 0);
    xferActive = 1;
    @(negedge clk);
    chk(flags() == 4'b0100, "R7 active tx req", flags(), 4'b0100);

    // R3 full discard, then R2 wrap drain
    writeCfg(16'h0001);
    for (int j = 0; j < 32; j++) pushWord(16'h5A00 + 16'(j), 1'b0);
    pushWord(16'hDEAD, 1'b0);
    @(negedge clk);
    chk(flags() == 4'b0000, "R3 full flags", flags(), 0);
    for (int j = 0; j < 32; j++) popWord(j[0], "R3 drain after discard");
    @(negedge clk);
    chk(flags() == 4'b0001, "R3 empty after 32 pops", flags(), 4'b0001);

    // R4 pop while empty
    @(negedge clk);
    chk(regRdData == mdl[mStart], "R4 empty read word", regRdData, mdl[mStart]);
    regRdEn = 1; @(negedge clk); regRdEn = 0;
    chk(regRdData == mdl[mStart], "R4 pointer held", regRdData, mdl[mStart]);
    chk(flags() == 4'b0001, "R4 count held", flags(), 4'b0001);
    pushWord(16'h1234, 1'b0);
    popWord(1'b1, "R4 next push pops");

    // R8 and R11: receive level bit follows push immediately, cleared by DMA enable
    writeCfg(16'h0000); dirRx = 1; xferActive = 1;
    @(negedge clk);
    chk(flags() == 4'b0000, "R11 before push", flags(), 0);
    pushWord(16'h7777, 1'b1);
    chk(flags() == 4'b0010, "R11 same cycle after push", flags(), 4'b0010);
    intMask = 15'h0400;
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq from level bit", irq, 1);
    writeCfg(16'h8000);
    chk(flags() == 4'b1000, "R8 dma enable clears bit", flags(), 4'b1000);
    chk(irq == 1'b0, "R9 irq drops", irq, 0);
    popWord(1'b0, "R2 single");

    // R9 R10 status merge and interrupt
    xferActive = 0; intMask = 15'h7FFF; otherStatus = 16'h8000;
    @(negedge clk);
    chk(irq == 1'b0, "R9 bit15 no irq", irq, 0);
    otherStatus = 16'h0C05; intMask = 15'h0001;
    @(negedge clk);
    chk(statusOut == 16'h0005, "R10 merge", statusOut, 16'h0005);
    chk(irq == 1'b1, "R9 masked bit", irq, 1);
    intMask = 15'h0000;
    @(negedge clk);
    chk(irq == 1'b0, "R9 mask off", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule